// File: doc/BRIEF.md
# Down-Counting Periodic Interrupt Timer

This block is a 32-bit timer that counts down from a programmed load value. Its step rate comes from one of two tick-enable inputs, a main peripheral tick and a slow tick, and then passes through a 12-bit prescaler. When the count arrives at zero the block sets a pending flag. On the next step the counter either reloads from the load register, which gives a periodic mode, or wraps to all-ones, which gives a free-running mode. A non-zero compare value sets the same flag when the count arrives at that value. The interrupt line is the flag gated by an interrupt-enable bit.

Software reaches the block through a synchronous word-addressed register port. The port has an address, a write strobe, write data and combinational read data. There are five words: control, status, load, compare and counter. The status word clears the flag on any write. The counter word is read-only. A write to the load word can also overwrite the live count at once, and a control write can restart the count from the load value.

Top module: `periodic_down_timer`

## Requirements
- R1: Word offsets are fixed: 0 is control, 1 is status, 2 is load, 3 is compare and 4 is counter. Load and compare read back what was written. A write to offset 4 leaves the count unchanged. Reads of unused offsets return 0.
- R2: Control fields: bit 0 enable, bit 1 keep-count (enable-mode), bit 2 interrupt enable, bit 3 reload select, bits 15:4 prescaler, bit 16 software reset, bit 17 load-overwrite, bits 25:24 tick source. Bits 31:26 always read 0, and bit 16 always reads 0.
- R3: Tick source code 0 stops counting. Codes 1 and 2 step on `tick_main`, and code 3 steps on `tick_slow`. The count moves once every (prescaler+1) selected ticks, and every control write restarts the prescaler phase.
- R4: Each step decrements the count. The step that brings the count to 0 sets the flag. The step taken from 0 loads the load value when reload select is 1, and loads all-ones when it is 0.
- R5: `irq` is high exactly when the flag is set and interrupt enable is 1. Status bit 0 reads the flag. Any status write clears the flag.
- R6: A load write with load-overwrite set also puts the written value into the counter on the same edge. With load-overwrite clear, the counter is untouched.
- R7: A control write that leaves enable=1 and keep-count=0 loads the counter from the load register. With keep-count=1 the count is kept. While enable=0 the count holds.
- R8: After reset, or after a control write with bit 16 set, control reads 0, compare reads 0, the flag is 0, and load and counter read all-ones. Any other fields of that same control write are then applied.
- R9: When compare is non-zero, the step that brings the count to the compare value sets the flag.
- R10: When a status write and a flag-setting step fall on the same edge, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Word offset |
| reg_we | input | 1 | Write strobe, one write per high cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tick_main | input | 1 | Main peripheral tick enable |
| tick_slow | input | 1 | Slow (32 kHz) tick enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps the prescaler over several settings and tick counts, and computes the expected count and flag arithmetically. A design that restarts the period one step early or late, or that does not restart the prescaler phase on a control write, reads back a count that is off by one. It also targets the two end-of-count modes. A design that wraps in reload mode, or reloads in free-run mode, shows 2 where all-ones less one is expected. The bench drives a status write on the same edge as the zero-reaching step. A design where the clear wins loses that interrupt. The other checks cover the software reset with its defaults, load-overwrite against a plain load, keep-count against a restarting enable, and a non-zero compare match, where a wrong design either misses the early flag or leaves stale values.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  localparam int REG_W   = 32;
  localparam int PRE_W   = 12;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_LOAD = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CMP  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 3'd4;

  localparam int B_EN     = 0;
  localparam int B_KEEP   = 1;
  localparam int B_IE     = 2;
  localparam int B_RLD    = 3;
  localparam int B_PRE    = 4;
  localparam int B_SWR    = 16;
  localparam int B_OVW    = 17;
  localparam int B_SRC    = 24;

  localparam logic [REG_W-1:0] CTRL_KEEP_MASK = 32'h03FE_FFFF;

  typedef struct packed {
    logic             en;
    logic             keep;
    logic             ie;
    logic             rld;
    logic [PRE_W-1:0] pre;
    logic             swr;
    logic             ovw;
    logic [1:0]       src;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.en   = w[B_EN];
    c.keep = w[B_KEEP];
    c.ie   = w[B_IE];
    c.rld  = w[B_RLD];
    c.pre  = w[B_PRE +: PRE_W];
    c.swr  = w[B_SWR];
    c.ovw  = w[B_OVW];
    c.src  = w[B_SRC +: 2];
    return c;
  endfunction
endpackage

// File: rtl/pdt_prescaler.sv
module pdt_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             enable,
  input  logic [1:0]       src_sel,
  input  logic             tick_main,
  input  logic             tick_slow,
  input  logic [PRE_W-1:0] divide,
  output logic             step
);
  logic [PRE_W-1:0] phase_q;
  logic             src_tick;

  always_comb begin
    unique case (src_sel)
      2'd1, 2'd2: src_tick = tick_main;
      2'd3:       src_tick = tick_slow;
      default:    src_tick = 1'b0;
    endcase
  end

  assign step = enable && src_tick && (phase_q == divide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase_q <= '0;
    else if (restart || !enable) phase_q <= '0;
    else if (src_tick)          phase_q <= (phase_q == divide) ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/pdt_counter.sv
module pdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             force_load,
  input  logic [CNT_W-1:0] force_val,
  input  logic             step,
  input  logic             reload_sel,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count,
  output logic             event_hit
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  logic [CNT_W-1:0] cnt_q, cnt_next;
  logic             live_step;

  assign live_step = step && !force_load && !soft_rst;

  always_comb begin
    if (cnt_q == '0) cnt_next = reload_sel ? load_val : ALL_ONES;
    else             cnt_next = cnt_q - 1'b1;
  end

  assign event_hit = live_step &&
                     ((cnt_next == '0) || ((cmp_val != '0) && (cnt_next == cmp_val)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= ALL_ONES;
    else if (force_load) cnt_q <= force_val;
    else if (soft_rst)   cnt_q <= ALL_ONES;
    else if (live_step)  cnt_q <= cnt_next;
  end

  assign count = cnt_q;
endmodule

// File: rtl/pdt_flag.sv
module pdt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic set_evt,
  input  logic clr_req,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (soft_rst) flag_q <= 1'b0;
    else if (set_evt)  flag_q <= 1'b1;
    else if (clr_req)  flag_q <= 1'b0;
  end

  assign flag = flag_q;
  assign irq  = flag_q && irq_en;
endmodule

// File: rtl/periodic_down_timer.sv
module periodic_down_timer
  import pdt_pkg::*;
#(
  parameter int CNT_W = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              tick_main,
  input  logic              tick_slow,
  output logic              irq
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [REG_W-1:0] ctrl_q;
  logic [CNT_W-1:0] load_q, cmp_q, cnt_q, force_val;
  ctrl_t            cur, nxt;
  logic             wr_ctrl, wr_stat, wr_load, wr_cmp, swr, force_load;
  logic             step, evt, flag_q;

  assign cur = decode_ctrl(ctrl_q);
  assign nxt = decode_ctrl(reg_wdata);

  assign wr_ctrl = reg_we && (reg_addr == OFS_CTRL);
  assign wr_stat = reg_we && (reg_addr == OFS_STAT);
  assign wr_load = reg_we && (reg_addr == OFS_LOAD);
  assign wr_cmp  = reg_we && (reg_addr == OFS_CMP);
  assign swr     = wr_ctrl && nxt.swr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= ALL_ONES;
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_KEEP_MASK;
      if (swr)          load_q <= ALL_ONES;
      else if (wr_load) load_q <= reg_wdata[CNT_W-1:0];
      if (swr)         cmp_q <= '0;
      else if (wr_cmp) cmp_q <= reg_wdata[CNT_W-1:0];
    end
  end

  assign force_load = (wr_ctrl && nxt.en && !nxt.keep) || (wr_load && cur.ovw);
  assign force_val  = wr_load ? reg_wdata[CNT_W-1:0] : (swr ? ALL_ONES : load_q);

  pdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(wr_ctrl), .enable(cur.en),
    .src_sel(cur.src), .tick_main(tick_main), .tick_slow(tick_slow),
    .divide(cur.pre), .step(step)
  );

  pdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .soft_rst(swr), .force_load(force_load),
    .force_val(force_val), .step(step), .reload_sel(cur.rld),
    .load_val(load_q), .cmp_val(cmp_q), .count(cnt_q), .event_hit(evt)
  );

  pdt_flag u_flag (
    .clk(clk), .rst_n(rst_n), .soft_rst(swr), .set_evt(evt),
    .clr_req(wr_stat), .irq_en(cur.ie), .flag(flag_q), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CTRL: reg_rdata = ctrl_q;
      OFS_STAT: reg_rdata[0] = flag_q;
      OFS_LOAD: reg_rdata[CNT_W-1:0] = load_q;
      OFS_CMP:  reg_rdata[CNT_W-1:0] = cmp_q;
      OFS_CNT:  reg_rdata[CNT_W-1:0] = cnt_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pdt_checker.sv
module pdt_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       reg_addr,
  input logic             reg_we,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic [31:0]      ctrl_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             flag_q,
  input logic             step,
  input logic             evt,
  input logic             irq
);
  assert_swr_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd0) |-> (reg_rdata[16] == 1'b0));

  assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && !reg_we) |=> $stable(cnt_q));

  assert_step_decrements_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !reg_we && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_zero_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !reg_we && cnt_q == 1) |=> flag_q);

  assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl_q[2] && flag_q));

  assert_status_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd1 && !evt) |=> !flag_q);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_q);

  assert_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd2 && ctrl_q[17]) |=> (cnt_q == $past(reg_wdata[CNT_W-1:0])));
endmodule

bind periodic_down_timer pdt_checker #(.CNT_W(CNT_W)) u_pdt_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctrl_q(ctrl_q),
  .cnt_q(cnt_q), .flag_q(flag_q), .step(step), .evt(evt), .irq(irq)
);

// File: tb/periodic_down_timer_bench.sv
module periodic_down_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick_main = 1'b0;
  logic        tick_slow = 1'b0;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periodic_down_timer u_periodic_down_timer (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_main(tick_main),
    .tick_slow(tick_slow), .irq(irq)
  );

  function automatic logic [31:0] mk_ctrl(input logic en, input logic keep, input logic ie,
                                          input logic rld, input int pre, input logic ovw,
                                          input int src);
    return {6'd0, src[1:0], 6'd0, ovw, 1'b0, pre[11:0], rld, ie, keep, en};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run(input logic m, input logic s, input int k);
    @(negedge clk);
    tick_main = m; tick_slow = s;
    repeat (k) @(negedge clk);
    tick_main = 1'b0; tick_slow = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset defaults
    rd(3'd0, v); chk("R8 ctrl after reset", v, 32'h0);
    rd(3'd2, v); chk("R8 load after reset", v, ONES);
    rd(3'd3, v); chk("R8 cmp after reset", v, 32'h0);
    rd(3'd4, v); chk("R8 cnt after reset", v, ONES);
    rd(3'd1, v); chk("R8 flag after reset", v, 32'h0);
    chk("R5 irq after reset", {31'd0, irq}, 32'h0);

    // R1: readback and unused offset
    wr(3'd3, 32'h0000_1234); rd(3'd3, v); chk("R1 cmp readback", v, 32'h1234);
    wr(3'd3, 32'h0);
    rd(3'd6, v); chk("R1 unused offset", v, 32'h0);

    // R2: upper bits and reset bit never read back
    wr(3'd0, 32'hFC00_0008); rd(3'd0, v); chk("R2 top bits dropped", v, 32'h8);

    // R3/R4: prescaler sweep, reload mode, load=5
    wr(3'd2, 32'd5);
    for (int pre = 0; pre < 4; pre++) begin
      for (int k = 1; k < 16; k += 5) begin
        int s;
        s = k / (pre + 1);
        wr(3'd1, 32'h0);
        wr(3'd0, mk_ctrl(1, 0, 0, 1, pre, 0, 1));
        run(1'b1, 1'b0, k);
        rd(3'd4, v); chk("R3 R4 sweep count", v, 32'(5 - (s % 6)));
        rd(3'd1, v); chk("R4 sweep flag", v, (s >= 5) ? 32'h1 : 32'h0);
      end
    end

    // R3: slow source ignores main tick; code 0 stops counting
    wr(3'd0, mk_ctrl(1, 0, 0, 1, 1, 0, 3));
    run(1'b1, 1'b0, 10);
    rd(3'd4, v); chk("R3 slow ignores main", v, 32'd5);
    run(1'b0, 1'b1, 6);
    rd(3'd4, v); chk("R3 slow divided", v, 32'd2);
    wr(3'd0, mk_ctrl(1, 0, 0, 1, 0, 0, 0));
    run(1'b1, 1'b1, 10);
    rd(3'd4, v); chk("R3 source 0 stops", v, 32'd5);
    wr(3'd0, mk_ctrl(1, 0, 0, 1, 0, 0, 2));
    run(1'b1, 1'b0, 2);
    rd(3'd4, v); chk("R3 source 2 uses main", v, 32'd3);

    // R9: non-zero compare
    wr(3'd3, 32'd2); wr(3'd1, 32'h0);
    wr(3'd0, mk_ctrl(1, 0, 0, 1, 0, 0, 1));
    run(1'b1, 1'b0, 2);
    rd(3'd1, v); chk("R9 no flag before match", v, 32'h0);
    run(1'b1, 1'b0, 1);
    rd(3'd4, v); chk("R9 count at match", v, 32'd2);
    rd(3'd1, v); chk("R9 flag on match", v, 32'h1);
    wr(3'd3, 32'h0);

    // R10: clear and zero-arrival on the same edge
    wr(3'd1, 32'h0);
    wr(3'd0, mk_ctrl(1, 0, 0, 1, 0, 0, 1));
    run(1'b1, 1'b0, 4);
    rd(3'd1, v); chk("R10 flag before collision", v, 32'h0);
    @(negedge clk);
    tick_main = 1'b1; reg_addr = 3'd1; reg_we = 1'b1; reg_wdata = 32'h1;
    @(negedge clk);
    tick_main = 1'b0; reg_we = 1'b0;
    rd(3'd4, v); chk("R10 count reached zero", v, 32'h0);
    rd(3'd1, v); chk("R10 set wins over clear", v, 32'h1);

    // R5/R7: keep-count enable and interrupt gating
    wr(3'd0, mk_ctrl(1, 1, 1, 1, 0, 0, 1));
    rd(3'd4, v); chk("R7 keep-count retains", v, 32'h0);
    #1 chk("R5 irq with enable", {31'd0, irq}, 32'h1);
    run(1'b1, 1'b0, 1);
    rd(3'd4, v); chk("R4 reload from zero", v, 32'd5);
    wr(3'd1, 32'h0);
    rd(3'd1, v); chk("R5 status write clears", v, 32'h0);
    #1 chk("R5 irq drops", {31'd0, irq}, 32'h0);

    // R6/R7/R1: overwrite, hold when disabled, counter read-only
    wr(3'd0, mk_ctrl(0, 0, 0, 0, 0, 1, 1));
    wr(3'd2, 32'd100);
    rd(3'd4, v); chk("R6 overwrite loads count", v, 32'd100);
    wr(3'd0, mk_ctrl(0, 0, 0, 0, 0, 0, 1));
    wr(3'd2, 32'd200);
    rd(3'd4, v); chk("R6 plain load keeps count", v, 32'd100);
    rd(3'd2, v); chk("R1 load readback", v, 32'd200);
    run(1'b1, 1'b1, 10);
    rd(3'd4, v); chk("R7 disabled holds", v, 32'd100);
    wr(3'd4, 32'd7);
    rd(3'd4, v); chk("R1 counter read-only", v, 32'd100);

    // R4: free-run wrap, load=3
    wr(3'd2, 32'd3); wr(3'd1, 32'h0);
    wr(3'd0, mk_ctrl(1, 0, 0, 0, 0, 0, 1));
    run(1'b1, 1'b0, 5);
    rd(3'd4, v); chk("R4 wrap to all-ones", v, ONES - 32'd1);
    rd(3'd1, v); chk("R4 wrap flag", v, 32'h1);

    // R8: software reset via control bit 16
    wr(3'd3, 32'd9);
    wr(3'd0, 32'h0001_0000);
    rd(3'd0, v); chk("R8 swr ctrl", v, 32'h0);
    rd(3'd2, v); chk("R8 swr load", v, ONES);
    rd(3'd3, v); chk("R8 swr cmp", v, 32'h0);
    rd(3'd4, v); chk("R8 swr cnt", v, ONES);
    rd(3'd1, v); chk("R8 swr flag", v, 32'h0);
    wr(3'd0, 32'h0001_0000 | mk_ctrl(1, 0, 0, 1, 0, 0, 1));
    rd(3'd0, v); chk("R2 R8 swr with fields", v, mk_ctrl(1, 0, 0, 1, 0, 0, 1));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule